// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns simple access requests into SDRAM command sequences for up to two module banks. Every accepted request is served closed-page: an ACTIVATE opens the row, one READ or WRITE is issued to the column, and a PRECHARGE closes the row. No row stays open between requests. Minimum spacings between commands come from one packed 32-bit timing word. A spacing field written as 0 behaves as a spacing of one clock.

The block raises refreshes on its own from a free-running interval counter, and also when a test input rises. A pending refresh blocks new requests. Refreshes go either to all module banks at once or to one module bank at a time. A rising edge on a program input issues one MODE REGISTER SET that carries the programmed CAS latency. An optional lead mode drives address and bank address for one clock with all chip selects deasserted before every command. The data path, CAS-latency capture, power-down and self-refresh are not modelled.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During and right after reset all chip selects are high, RAS#/CAS#/WE# are high, and req_ready is 1.
- R2: Commands use the active-low pin code {ras_n,cas_n,we_n}: ACTIVATE 011, READ 101, WRITE 100, PRECHARGE 010, REFRESH 001, MODE REGISTER SET 000, with at least one cs_n low. ACTIVATE carries the row on addr. READ/WRITE carries the column on addr. ACTIVATE, READ/WRITE and PRECHARGE carry the request's component bank on ba, and only the requested module bank's cs_n is low.
- R3: Timing word bits 14:12 set the ACTIVATE to READ/WRITE spacing. With no address lead, the READ/WRITE comes exactly that many clocks after the ACTIVATE, and exactly 1 clock when the field is 0.
- R4: A PRECHARGE comes at least field 23:20 clocks after its ACTIVATE, and at least field 6:4 clocks after a preceding WRITE (0 counts as 1).
- R5: An ACTIVATE comes at least field 18:16 clocks after the last PRECHARGE. A REFRESH or ACTIVATE comes at least field 27:24 clocks after the last REFRESH. Two ACTIVATEs are spaced at least field 10:8 clocks apart. In all three, 0 counts as 1.
- R6: Two ACTIVATE commands never follow each other without a READ or WRITE between them.
- R7: A 0-to-1 change of mode_prog issues exactly one MODE REGISTER SET, to all module banks, with addr[6:4] equal to timing bits 30:28 and the other addr bits 0. Holding mode_prog at 1 issues nothing more.
- R8: With addr_lead_en set, the clock before every command has all cs_n high and the same ba and addr as the command.
- R9: A REFRESH is requested every REF_PERIOD clocks, and also on each rising edge of force_refresh.
- R10: With ref_stagger at 0, a REFRESH drives all cs_n low together. With ref_stagger at 1, each refresh request gives one REFRESH per module bank, module bank 0 first, each with a single cs_n low.
- R11: While a refresh is pending, req_ready is 0. A request that arrives while a refresh is pending gets its ACTIVATE only after the REFRESH. A request accepted in the same clock that the refresh is raised finishes with its PRECHARGE before the REFRESH.
- R12: req_ready is 1 only when an ACTIVATE may start. A request is taken in a clock where req_valid and req_ready are both 1, and produces exactly one ACTIVATE, one READ or WRITE, and one PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_reg | input | 32 | Packed spacing and CAS latency fields |
| ref_stagger | input | 1 | Refresh one module bank at a time |
| addr_lead_en | input | 1 | One clock of address lead before chip select |
| force_refresh | input | 1 | Rising edge requests a refresh |
| mode_prog | input | 1 | Rising edge requests a mode register set |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mbank | input | MB_W | Module bank select |
| req_cbank | input | BA_W | Component bank |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cs_n | output | NUM_MB | Chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/column/mode address |

## Verification
Two functions can fall in the same clock: a refresh request, from force_refresh or the interval counter, and the arrival of a new access request. The bench raises force_refresh together with req_valid in two situations. In the first, an access is already in flight, so req_ready is low. There the REFRESH must appear on the pins before the new ACTIVATE. In the second, the block is idle and req_ready is high. There the request is taken in that clock, and its PRECHARGE must come before the REFRESH. A monitor on the command pins checks every spacing rule against values the bench computes from the timing word it programmed.

// File: rtl/sdram_seq_pkg.sv
// Shared types and helpers for the SDRAM command sequencer.
// Assumes a single-clock design; all counts are in SDRAM clocks.
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS
    } cmd_e;

    typedef struct packed {
        logic [2:0] cl;
        logic [3:0] rc;
        logic [3:0] ras;
        logic [2:0] rp;
        logic [2:0] rcd;
        logic [2:0] rrd;
        logic [2:0] dpl;
    } timing_t;

    // Pull the timing fields out of the packed word (positions fixed).
    function automatic timing_t unpack_timing(input logic [31:0] r);
        timing_t t;
        t.cl  = r[30:28];
        t.rc  = r[27:24];
        t.ras = r[23:20];
        t.rp  = r[18:16];
        t.rcd = r[14:12];
        t.rrd = r[10:8];
        t.dpl = r[6:4];
        return t;
    endfunction

    // Spacing minus one, where a field of 0 is treated as a spacing of 1.
    function automatic logic [3:0] span_m1(input logic [3:0] v);
        return (v == 4'd0) ? 4'd0 : v - 4'd1;
    endfunction

    // Active-low {ras_n, cas_n, we_n} code for a command.
    function automatic logic [2:0] pin_code(input cmd_e c);
        case (c)
            C_ACT:   return 3'b011;
            C_RD:    return 3'b101;
            C_WR:    return 3'b100;
            C_PRE:   return 3'b010;
            C_REF:   return 3'b001;
            C_MRS:   return 3'b000;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/seq_gap_timer.sv
// Down-counter that holds a minimum spacing. Loading it with N makes
// done go high N clocks later. Assumes load_val fits in W bits.
module seq_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Load on command issue, else count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/seq_refresh_req.sv
// Refresh request source: a free-running interval counter plus the rising
// edge of a test input. The pending flag holds until the sequencer clears it.
// A new request in the clearing cycle wins, so none is lost.
module seq_refresh_req #(
    parameter int REF_PERIOD = 1560,
    localparam int CW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_refresh,
    input  logic clr,
    output logic pend
);
    logic [CW-1:0] cnt_q;
    logic          force_q;
    logic          tick;

    assign tick = (cnt_q == CW'(REF_PERIOD - 1)) || (force_refresh && !force_q);

    // Interval counter wraps every REF_PERIOD clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (cnt_q == CW'(REF_PERIOD - 1)) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // Edge detector and pending flag; a new request beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= 1'b0;
            pend    <= 1'b0;
        end else begin
            force_q <= force_refresh;
            pend    <= tick | (pend & ~clr);
        end
    end

endmodule

// File: rtl/seq_cmd_out.sv
// Output register stage: holds the command, chip selects, bank and
// address, and encodes the active-low strobes. In a lead cycle it drives
// ba/addr with all chip selects off.
module seq_cmd_out
    import sdram_seq_pkg::*;
#(
    parameter int NUM_MB = 2,
    parameter int BA_W   = 2,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              lead,
    input  cmd_e              want_cmd,
    input  logic [NUM_MB-1:0] want_cs,
    input  logic [BA_W-1:0]   want_ba,
    input  logic [ADDR_W-1:0] want_addr,
    output cmd_e              cmd_o,
    output logic [NUM_MB-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    logic [NUM_MB-1:0] cs_q;

    // Register the command or lead pattern; idle clocks keep the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o <= C_NOP;
            cs_q  <= '0;
            ba    <= '0;
            addr  <= '0;
        end else if (issue) begin
            cmd_o <= want_cmd;
            cs_q  <= want_cs;
            ba    <= want_ba;
            addr  <= want_addr;
        end else begin
            cmd_o <= C_NOP;
            cs_q  <= '0;
            if (lead) begin
                ba   <= want_ba;
                addr <= want_addr;
            end
        end
    end

    assign cs_n = ~cs_q;
    assign {ras_n, cas_n, we_n} = pin_code(cmd_o);

endmodule

// File: rtl/sdram_cmd_seq.sv
// SDRAM command timing sequencer. Serves each request closed-page
// (ACT, RD/WR, PRE), refreshes on demand, and issues a mode register set
// on a rising program edge. Spacings come from a packed timing word.
// Assumes the timing word and mode inputs change only while idle.
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int NUM_MB     = 2,
    parameter int BA_W       = 2,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 10,
    parameter int ADDR_W     = 13,
    parameter int REF_PERIOD = 1560,
    parameter int MRD        = 2,
    localparam int MB_W      = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       timing_reg,
    input  logic              ref_stagger,
    input  logic              addr_lead_en,
    input  logic              force_refresh,
    input  logic              mode_prog,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [MB_W-1:0]   req_mbank,
    input  logic [BA_W-1:0]   req_cbank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [NUM_MB-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int TW    = 4;
    localparam int NT    = 3;
    localparam int T_GAP = 0;
    localparam int T_RAS = 1;
    localparam int T_RRD = 2;
    localparam logic [MB_W-1:0] LAST_MB = MB_W'(NUM_MB - 1);
    localparam logic STAG_OK = (NUM_MB > 1);

    typedef enum logic [2:0] {S_IDLE, S_ACT, S_RW, S_PRE, S_REF2} st_e;

    timing_t tm;
    assign tm = unpack_timing(timing_reg);

    logic unused_bits;
    assign unused_bits = ^{timing_reg[31], timing_reg[19], timing_reg[15],
                           timing_reg[11], timing_reg[7], timing_reg[3:0]};

    st_e               st_q;
    logic              lead_q;
    cmd_e              pick_q, pick;
    logic              lat_wr;
    logic [MB_W-1:0]   lat_mb, ref_idx;
    logic [BA_W-1:0]   lat_cb;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic              mode_q, mrs_pend, ref_pend, ref_clr;

    cmd_e              want_cmd, out_cmd;
    logic [NUM_MB-1:0] want_cs;
    logic [BA_W-1:0]   want_ba;
    logic [ADDR_W-1:0] want_addr;
    logic              want_ok, issue, go_lead, accept;

    logic [NT-1:0]     t_load, t_done;
    logic [TW-1:0]     t_val [NT];

    // One spacing timer per constraint: shared gap, ACT-to-PRE, ACT-to-ACT.
    for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
        seq_gap_timer #(.W(TW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (t_load[gi]),
            .load_val (t_val[gi]),
            .done     (t_done[gi])
        );
    end

    seq_refresh_req #(.REF_PERIOD(REF_PERIOD)) u_ref (
        .clk           (clk),
        .rst_n         (rst_n),
        .force_refresh (force_refresh),
        .clr           (ref_clr),
        .pend          (ref_pend)
    );

    assign req_ready = (st_q == S_IDLE) && !ref_pend && !mrs_pend && !lead_q &&
                       t_done[T_GAP] && t_done[T_RRD];
    assign accept    = req_valid && req_ready;

    // Choose the next command, its pins, and whether its spacing has expired.
    always_comb begin
        pick      = lead_q ? pick_q : (ref_pend ? C_REF : (mrs_pend ? C_MRS : C_NOP));
        want_cmd  = C_NOP;
        want_cs   = '0;
        want_ba   = '0;
        want_addr = '0;
        want_ok   = 1'b0;
        case (st_q)
            S_IDLE: begin
                if (pick == C_REF) begin
                    want_cmd = C_REF;
                    want_cs  = (ref_stagger && STAG_OK) ? NUM_MB'(1) : '1;
                    want_ok  = t_done[T_GAP];
                end else if (pick == C_MRS) begin
                    want_cmd  = C_MRS;
                    want_cs   = '1;
                    want_addr = ADDR_W'({tm.cl, 4'b0000});
                    want_ok   = t_done[T_GAP];
                end
            end
            S_ACT: begin
                want_cmd  = C_ACT;
                want_cs   = NUM_MB'(1) << lat_mb;
                want_ba   = lat_cb;
                want_addr = ADDR_W'(lat_row);
                want_ok   = t_done[T_GAP] && t_done[T_RRD];
            end
            S_RW: begin
                want_cmd  = lat_wr ? C_WR : C_RD;
                want_cs   = NUM_MB'(1) << lat_mb;
                want_ba   = lat_cb;
                want_addr = ADDR_W'(lat_col);
                want_ok   = t_done[T_GAP];
            end
            S_PRE: begin
                want_cmd = C_PRE;
                want_cs  = NUM_MB'(1) << lat_mb;
                want_ba  = lat_cb;
                want_ok  = t_done[T_GAP] && t_done[T_RAS];
            end
            S_REF2: begin
                want_cmd = C_REF;
                want_cs  = NUM_MB'(1) << ref_idx;
                want_ok  = t_done[T_GAP];
            end
            default: ;
        endcase
        go_lead = want_ok && addr_lead_en && !lead_q;
        issue   = want_ok && !go_lead;
    end

    // Spacing to load into each timer when a command goes out.
    always_comb begin
        t_load        = '0;
        t_load[T_GAP] = issue;
        t_load[T_RAS] = issue && (want_cmd == C_ACT);
        t_load[T_RRD] = issue && (want_cmd == C_ACT);
        t_val[T_RAS]  = span_m1(tm.ras);
        t_val[T_RRD]  = span_m1({1'b0, tm.rrd});
        case (want_cmd)
            C_ACT:   t_val[T_GAP] = span_m1({1'b0, tm.rcd});
            C_WR:    t_val[T_GAP] = span_m1({1'b0, tm.dpl});
            C_PRE:   t_val[T_GAP] = span_m1({1'b0, tm.rp});
            C_REF:   t_val[T_GAP] = span_m1(tm.rc);
            C_MRS:   t_val[T_GAP] = TW'(MRD - 1);
            default: t_val[T_GAP] = '0;
        endcase
    end

    assign ref_clr = issue && (want_cmd == C_REF) &&
                     ((st_q == S_REF2) ? (ref_idx == LAST_MB) : !(ref_stagger && STAG_OK));

    // Sequencer state, lead cycle flag and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            lead_q  <= 1'b0;
            pick_q  <= C_NOP;
            ref_idx <= '0;
            lat_wr  <= 1'b0;
            lat_mb  <= '0;
            lat_cb  <= '0;
            lat_row <= '0;
            lat_col <= '0;
        end else begin
            if (go_lead) begin
                lead_q <= 1'b1;
                pick_q <= pick;
            end else if (issue) begin
                lead_q <= 1'b0;
            end
            if (accept) begin
                st_q    <= S_ACT;
                lat_wr  <= req_write;
                lat_mb  <= req_mbank;
                lat_cb  <= req_cbank;
                lat_row <= req_row;
                lat_col <= req_col;
            end else if (issue) begin
                case (st_q)
                    S_IDLE: if (want_cmd == C_REF && ref_stagger && STAG_OK) begin
                                st_q    <= S_REF2;
                                ref_idx <= MB_W'(1);
                            end
                    S_ACT:  st_q <= S_RW;
                    S_RW:   st_q <= S_PRE;
                    S_PRE:  st_q <= S_IDLE;
                    S_REF2: if (ref_idx == LAST_MB) st_q <= S_IDLE;
                            else ref_idx <= ref_idx + 1'b1;
                    default: st_q <= S_IDLE;
                endcase
            end
        end
    end

    // Mode program edge detector and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            mrs_pend <= 1'b0;
        end else begin
            mode_q   <= mode_prog;
            mrs_pend <= (mode_prog && !mode_q) || (mrs_pend && !(issue && want_cmd == C_MRS));
        end
    end

    seq_cmd_out #(.NUM_MB(NUM_MB), .BA_W(BA_W), .ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .lead      (go_lead),
        .want_cmd  (want_cmd),
        .want_cs   (want_cs),
        .want_ba   (want_ba),
        .want_addr (want_addr),
        .cmd_o     (out_cmd),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr)
    );

    // Tracks an ACTIVATE on the pins not yet followed by a READ/WRITE.
    logic act_open_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                                  act_open_q <= 1'b0;
        else if (out_cmd == C_ACT)                   act_open_q <= 1'b1;
        else if (out_cmd == C_RD || out_cmd == C_WR) act_open_q <= 1'b0;
    end

    // R6
    act_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cmd == C_ACT) |-> !act_open_q);

    // R7
    mrs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cmd == C_MRS) |=> (out_cmd != C_MRS));

    // R8
    lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr_lead_en) && out_cmd != C_NOP) |->
        ($past(cs_n) == '1 && $stable(addr) && $stable(ba)));

    // R10
    stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cmd == C_REF && $past(ref_stagger) && STAG_OK) |-> ($countones(~cs_n) == 1));

    // R10
    ref_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cmd == C_REF && !$past(ref_stagger)) |-> (cs_n == '0));

    // R12
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;
    localparam int REFP = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_reg = '0;
    logic        ref_stagger = 1'b0, addr_lead_en = 1'b0;
    logic        force_refresh = 1'b0, mode_prog = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic        req_mbank = 1'b0;
    logic [1:0]  req_cbank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [1:0]  cs_n;
    logic        ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;

    sdram_cmd_seq #(.REF_PERIOD(REFP)) dut_i (
        .clk(clk), .rst_n(rst_n), .timing_reg(timing_reg), .ref_stagger(ref_stagger),
        .addr_lead_en(addr_lead_en), .force_refresh(force_refresh), .mode_prog(mode_prog),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_mbank(req_mbank), .req_cbank(req_cbank), .req_row(req_row), .req_col(req_col),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

    always #2 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;
    int cl_b, rc_b, ras_b, rp_b, rcd_b, rrd_b, dpl_b;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic set_timing(input int cl, input int rc, input int ras, input int rp,
                              input int rcd, input int rrd, input int dpl);
        cl_b = cl; rc_b = rc; ras_b = ras; rp_b = rp; rcd_b = rcd; rrd_b = rrd; dpl_b = dpl;
        timing_reg = (32'(cl) << 28) | (32'(rc) << 24) | (32'(ras) << 20) | (32'(rp) << 16) |
                     (32'(rcd) << 12) | (32'(rrd) << 8) | (32'(dpl) << 4);
        repeat (20) @(negedge clk);
    endtask

    // ---------------- pin monitor ----------------
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_act = 0, n_rd = 0, n_wr = 0, n_pre = 0, n_ref = 0, n_mrs = 0;
    longint last_act = -1000, last_rw = -1000, last_wr = -1000, last_pre = -1000, last_ref = -1000;
    bit prev_wr = 0, act_open = 0;
    logic [12:0] act_addr, rw_addr, mrs_addr, prev_addr;
    logic [1:0]  act_ba, act_cs, prev_ba, prev_cs, last_ref_cs;
    logic [1:0]  ref_log [8];
    longint      ref_cyc_log [8];

    always @(negedge clk) begin
        if (rst_n && cs_n != 2'b11) begin
            if (addr_lead_en)
                chk(prev_cs == 2'b11 && prev_addr == addr && prev_ba == ba,
                    "R8", "lead cycle address", longint'(prev_addr), longint'(addr));
            case ({ras_n, cas_n, we_n})
                3'b011: begin
                    chk(!act_open, "R6", "ACT without RD/WR between", 1, 0);
                    chk(cyc - last_pre >= eff(rp_b), "R5", "PRE->ACT", cyc - last_pre, eff(rp_b));
                    chk(cyc - last_ref >= eff(rc_b), "R5", "REF->ACT", cyc - last_ref, eff(rc_b));
                    chk(cyc - last_act >= eff(rrd_b), "R5", "ACT->ACT", cyc - last_act, eff(rrd_b));
                    act_open = 1; last_act = cyc; n_act++;
                    act_addr = addr; act_ba = ba; act_cs = cs_n;
                end
                3'b101, 3'b100: begin
                    chk(cyc - last_act >= eff(rcd_b), "R3", "ACT->RW", cyc - last_act, eff(rcd_b));
                    act_open = 0; last_rw = cyc; rw_addr = addr;
                    prev_wr = !we_n;
                    if (!we_n) begin n_wr++; last_wr = cyc; end else n_rd++;
                end
                3'b010: begin
                    chk(cyc - last_act >= eff(ras_b), "R4", "ACT->PRE", cyc - last_act, eff(ras_b));
                    if (prev_wr)
                        chk(cyc - last_wr >= eff(dpl_b), "R4", "WR->PRE", cyc - last_wr, eff(dpl_b));
                    last_pre = cyc; n_pre++;
                end
                3'b001: begin
                    chk(cyc - last_ref >= eff(rc_b), "R5", "REF->REF", cyc - last_ref, eff(rc_b));
                    ref_log[n_ref % 8] = cs_n; ref_cyc_log[n_ref % 8] = cyc;
                    last_ref = cyc; last_ref_cs = cs_n; n_ref++;
                end
                3'b000: begin n_mrs++; mrs_addr = addr; end
                default: chk(0, "R2", "illegal pin code", longint'({ras_n, cas_n, we_n}), 0);
            endcase
        end
        prev_cs = cs_n; prev_addr = addr; prev_ba = ba;
    end

    // ---------------- request helper ----------------
    task automatic do_req(input bit wr, input bit mb, input int cb, input int row, input int col);
        int p0 = n_pre;
        int k = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_mbank = mb;
        req_cbank = 2'(cb); req_row = 13'(row); req_col = 10'(col);
        while (!req_ready && k < 500) begin @(negedge clk); k++; end
        @(negedge clk);
        req_valid = 0;
        k = 0;
        while (n_pre == p0 && k < 500) begin @(negedge clk); k++; end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        @(negedge clk);
        chk(cs_n == 2'b11, "R1", "cs_n after reset", cs_n, 3);
        chk({ras_n, cas_n, we_n} == 3'b111, "R1", "strobes after reset", {ras_n, cas_n, we_n}, 7);
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    endtask

    task automatic t_read;
        int a0 = n_act, r0 = n_rd, p0 = n_pre;
        set_timing(3, 6, 5, 3, 3, 2, 2);
        do_req(0, 1, 2, 13'h1abc, 10'h155);
        chk(n_act - a0 == 1 && n_rd - r0 == 1 && n_pre - p0 == 1, "R12", "one ACT/RD/PRE",
            n_act - a0 + n_rd - r0 + n_pre - p0, 3);
        chk(act_addr == 13'h1abc, "R2", "ACT row", act_addr, 13'h1abc);
        chk(rw_addr == 13'h155, "R2", "RD column", rw_addr, 13'h155);
        chk(act_ba == 2 && act_cs == 2'b01, "R2", "ACT bank/cs", {act_ba, act_cs}, {2'd2, 2'b01});
        chk(last_rw - last_act == 3, "R3", "exact tRCD", last_rw - last_act, 3);
    endtask

    task automatic t_write;
        int w0 = n_wr;
        set_timing(2, 4, 2, 2, 2, 1, 6);
        do_req(1, 0, 1, 13'h0042, 10'h3ff);
        chk(n_wr - w0 == 1, "R12", "one WR", n_wr - w0, 1);
        chk(last_pre - last_wr >= 6, "R4", "tDPL honoured", last_pre - last_wr, 6);
        chk(act_cs == 2'b10, "R2", "module bank 0 cs", act_cs, 2'b10);
    endtask

    task automatic t_zero;
        set_timing(0, 0, 0, 0, 0, 0, 0);
        do_req(0, 0, 0, 5, 6);
        chk(last_rw - last_act == 1, "R3", "zero field spacing", last_rw - last_act, 1);
        do_req(1, 1, 3, 7, 8);
        chk(last_pre - last_wr >= 1, "R4", "zero tDPL", last_pre - last_wr, 1);
    endtask

    task automatic t_burst;
        int a0 = n_act;
        set_timing(2, 3, 3, 2, 2, 3, 1);
        for (int i = 0; i < 4; i++) do_req(i[0], i[0], i, 100 + i, i);
        chk(n_act - a0 == 4, "R6", "four ACTs each paired", n_act - a0, 4);
    endtask

    task automatic t_mrs;
        int m0 = n_mrs;
        set_timing(5, 2, 2, 2, 2, 1, 1);
        @(negedge clk); mode_prog = 1;
        repeat (40) @(negedge clk);
        chk(n_mrs - m0 == 1, "R7", "single MRS while held", n_mrs - m0, 1);
        chk(mrs_addr == 13'(5 << 4), "R7", "MRS latency field", mrs_addr, 5 << 4);
        mode_prog = 0; repeat (5) @(negedge clk);
        mode_prog = 1; repeat (40) @(negedge clk);
        chk(n_mrs - m0 == 2, "R7", "second edge gives second MRS", n_mrs - m0, 2);
        mode_prog = 0;
    endtask

    task automatic t_lead;
        int a0 = n_act;
        addr_lead_en = 1;
        set_timing(3, 4, 4, 2, 2, 2, 2);
        do_req(0, 1, 1, 13'h0777, 10'h021);
        chk(n_act - a0 == 1 && act_addr == 13'h0777, "R8", "ACT with lead", act_addr, 13'h0777);
        addr_lead_en = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_refresh_timer;
        int r0;
        ref_stagger = 0;
        set_timing(2, 5, 3, 2, 2, 1, 1);
        r0 = n_ref;
        repeat (3 * REFP) @(negedge clk);
        chk(n_ref - r0 == 3, "R9", "refresh count over 3 periods", n_ref - r0, 3);
        chk(last_ref_cs == 2'b00, "R10", "REF to all module banks", last_ref_cs, 0);
    endtask

    task automatic t_stagger;
        int r0;
        ref_stagger = 1;
        set_timing(2, 5, 3, 2, 2, 1, 1);
        r0 = n_ref;
        @(negedge clk); force_refresh = 1;
        @(negedge clk); force_refresh = 0;
        repeat (60) @(negedge clk);
        chk(n_ref - r0 >= 2, "R9", "force edge gives refresh", n_ref - r0, 2);
        chk(ref_log[r0 % 8] == 2'b10, "R10", "first staggered REF bank 0", ref_log[r0 % 8], 2'b10);
        chk(ref_log[(r0 + 1) % 8] == 2'b01, "R10", "second staggered REF bank 1",
            ref_log[(r0 + 1) % 8], 2'b01);
        chk(ref_cyc_log[(r0 + 1) % 8] - ref_cyc_log[r0 % 8] >= 5, "R10", "staggered spacing",
            ref_cyc_log[(r0 + 1) % 8] - ref_cyc_log[r0 % 8], 5);
        ref_stagger = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_priority;
        int a0, r0, k;
        longint pre_a;
        set_timing(2, 4, 2, 2, 2, 1, 6);
        // Part 1: refresh and new request together while an access is in flight.
        a0 = n_act; r0 = n_ref;
        @(negedge clk); req_valid = 1; req_write = 1; req_mbank = 0; req_cbank = 0;
        k = 0; while (!req_ready && k < 500) begin @(negedge clk); k++; end
        @(negedge clk); req_valid = 0;
        k = 0; while (n_act == a0 && k < 500) begin @(negedge clk); k++; end
        force_refresh = 1; req_valid = 1; req_write = 0; req_row = 13'h0123;
        @(negedge clk); force_refresh = 0;
        chk(req_ready == 0, "R11", "ready low with refresh pending", req_ready, 0);
        k = 0; while (!req_ready && k < 500) begin @(negedge clk); k++; end
        @(negedge clk); req_valid = 0;
        k = 0; while (n_act < a0 + 2 && k < 500) begin @(negedge clk); k++; end
        chk(n_ref > r0, "R11", "refresh issued", n_ref - r0, 1);
        chk(last_ref < last_act, "R11", "REF before new ACT", last_ref, last_act);
        repeat (30) @(negedge clk);
        // Part 2: same clock while idle and ready; the request is taken first.
        r0 = n_ref; a0 = n_act;
        @(negedge clk);
        chk(req_ready == 1, "R12", "idle ready", req_ready, 1);
        force_refresh = 1; req_valid = 1; req_row = 13'h0456;
        @(negedge clk); force_refresh = 0; req_valid = 0;
        k = 0; while (n_ref == r0 && k < 500) begin @(negedge clk); k++; end
        pre_a = last_pre;
        chk(n_act - a0 == 1, "R12", "request taken with refresh", n_act - a0, 1);
        chk(last_ref > pre_a && pre_a > last_act, "R11", "PRE before REF", last_ref, pre_a);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_read();
        t_write();
        t_zero();
        t_burst();
        t_mrs();
        t_lead();
        t_refresh_timer();
        t_stagger();
        t_priority();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            chk(0, "R12", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule